// File: doc/BRIEF.md
# Halfword Mask Memory Pattern Tester

The block tests a 1024-word region of 32-bit memory. After a start pulse it fills the region through a synchronous write port, one word per cycle, with a fixed pattern. Each word's two 16-bit halves are either all ones or all zeros, decided by one bit of an 8-bit group counter. It then reads the region back through a separate read port and compares every word against the same pattern, regenerating it on the fly rather than storing it. This read-and-compare sweep is done twice in a row.

The first word that differs ends the whole test. No further reads are issued, `err` is set and `failIndex` holds the word address that failed. If both sweeps are clean, `err` stays low and `failIndex` stays zero. `done` rises when the test ends and stays high until the next start. A tuning loop typically runs the block once per candidate setting of the memory path and keeps the settings that pass.

Top module: `mem_pattern_tester`

## Requirements
- R1: While reset is held and after it, before any start, `done`, `err`, `failIndex`, `wrEn` and `rdEn` are all zero.
- R2: The word for address a (10 bits) uses group g = a[9:2] and slot k = a[1:0]. Its low 16 bits are 0xFFFF when bit 2k of g is set and zero otherwise. Its high 16 bits are 0xFFFF when bit 2k+1 of g is set and zero otherwise.
- R3: After start, addresses 0 to 1023 are written in ascending order, one per cycle with no gaps. All of them are written before the first read, and `wrEn` and `rdEn` are never high together.
- R4: With no mismatch, exactly two ascending read sweeps of addresses 0 to 1023 are issued, 2048 reads in total. Read data is taken on `rdData` in the cycle after `rdEn`.
- R5: On the first mismatch at address A, `err` goes to 1 and `failIndex` to A. The test stops, and the total number of reads issued is A+1 in the first sweep, or 1024+A+1 in the second. No read or write is issued while `done` is high.
- R6: A word that compares correctly in the first sweep but wrong in the second is still caught.
- R7: When `err` is 0, `failIndex` is 0. `done` stays high until a new start.
- R8: A start pulse during a running test has no effect on its writes, its reads or its result.
- R9: A start pulse while `done` is high clears `done`, `err` and `failIndex` and runs the full test again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start pulse |
| wrEn | output | 1 | Memory write strobe |
| wrAddr | output | 10 | Memory write word address |
| wrData | output | 32 | Memory write data |
| rdEn | output | 1 | Memory read strobe |
| rdAddr | output | 10 | Memory read word address |
| rdData | input | 32 | Read data, valid one cycle after rdEn |
| done | output | 1 | Test finished, held until next start |
| err | output | 1 | A mismatch was found |
| failIndex | output | 10 | Address of the first mismatch, zero when err is 0 |

## Verification
The bench plants single-word corruptions at random addresses and masks, and also at the two ends of the region (address 0 and address 1023) in each sweep. Address 1023 in the first sweep is the hardest of these: a design that does not stop would issue the first read of the second sweep, and a design that reports one cycle late would give the wrong index. Faults present only in the second sweep catch a design that runs one sweep or stops counting sweeps early. Exact read counts expose a design that keeps reading past the failure. A start pulse in the middle of a test, and a clean run after a failed one, catch designs that restart while busy or keep a stale error and index.

// File: rtl/mem_pattern_pkg.sv
package mem_pattern_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrAll;   // reset the address, the sweep count and the result
    logic wrStb;    // issue a write at the current address
    logic rdStb;    // issue a read at the current address
    logic setErr;   // latch the compared address as the failure
  } dpCtrl_t;

  // Status from the datapath back to the sequencer
  typedef struct packed {
    logic addrLast;   // current address is the top of the region
    logic passLast;   // current sweep is the final one
    logic cmpMiss;    // the word compared this cycle differs
  } dpStat_t;

endpackage

// File: rtl/mem_pattern_ctrl.sv
module mem_pattern_ctrl
  import mem_pattern_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    done
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_FLUSH,
    ST_FIN
  } seqState_t;

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.clrAll = 1'b1;
          stateNext  = ST_WRITE;
        end
      end
      ST_WRITE: begin
        ctl.wrStb = 1'b1;
        if (stat.addrLast) stateNext = ST_READ;
      end
      ST_READ: begin
        if (stat.cmpMiss) begin
          ctl.setErr = 1'b1;
          stateNext  = ST_FIN;
        end else begin
          ctl.rdStb = 1'b1;
          if (stat.addrLast && stat.passLast) stateNext = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        // The final read is compared in this cycle
        ctl.setErr = stat.cmpMiss;
        stateNext  = ST_FIN;
      end
      ST_FIN: begin
        done = 1'b1;
        if (start) begin
          ctl.clrAll = 1'b1;
          stateNext  = ST_WRITE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  AST_NO_ISSUE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(ctl.wrStb || ctl.rdStb)); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R7

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrStb || ctl.rdStb) |-> !ctl.clrAll); // R8

endmodule

// File: rtl/mem_pattern_dp.sv
module mem_pattern_dp
  import mem_pattern_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int PASSES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  output dpStat_t           stat,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              err,
  output logic [ADDR_W-1:0] failIndex
);

  localparam int SEL_W  = 2;                       // four words per group
  localparam int IDX_W  = ADDR_W - SEL_W;          // group counter width
  localparam int HALF_W = DATA_W / 2;
  localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASSES - 1);

  function automatic logic [DATA_W-1:0] patWord(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] grp;
    logic [SEL_W-1:0] slot;
    logic             lo, hi;
    grp  = a[ADDR_W-1:SEL_W];
    slot = a[SEL_W-1:0];
    lo   = grp[{slot, 1'b0}];
    hi   = grp[{slot, 1'b1}];
    return {{HALF_W{hi}}, {HALF_W{lo}}};
  endfunction

  logic [ADDR_W-1:0] addr;
  logic [PASS_W-1:0] passCnt;
  logic              cmpValid;
  logic [ADDR_W-1:0] cmpAddr;
  logic              cmpMiss;

  // Issue address and sweep counter
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrAll) begin
      addr    <= '0;
      passCnt <= '0;
    end else if (ctl.wrStb || ctl.rdStb) begin
      addr <= addr + 1'b1;
      if (ctl.rdStb && addr == ADDR_LAST && passCnt != PASS_LAST)
        passCnt <= passCnt + 1'b1;
    end
  end

  // One-cycle compare pipeline aligned with the memory read latency
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrAll) begin
      cmpValid <= 1'b0;
      cmpAddr  <= '0;
    end else begin
      cmpValid <= ctl.rdStb;
      cmpAddr  <= addr;
    end
  end

  assign cmpMiss = cmpValid && (rdData != patWord(cmpAddr));

  // Result registers
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrAll) begin
      err       <= 1'b0;
      failIndex <= '0;
    end else if (ctl.setErr && !err) begin
      err       <= 1'b1;
      failIndex <= cmpAddr;
    end
  end

  assign stat.addrLast = (addr == ADDR_LAST);
  assign stat.passLast = (passCnt == PASS_LAST);
  assign stat.cmpMiss  = cmpMiss;

  assign wrEn   = ctl.wrStb;
  assign wrAddr = addr;
  assign wrData = patWord(addr);
  assign rdEn   = ctl.rdStb;
  assign rdAddr = addr;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.wrStb || ctl.rdStb) && $past(ctl.wrStb || ctl.rdStb))
      |-> addr == $past(addr) + 1'b1); // R3

  AST_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !err |-> failIndex == '0); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (err && !ctl.clrAll) |=> (err && $stable(failIndex))); // R5

endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester
  import mem_pattern_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int PASSES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] failIndex
);

  dpCtrl_t ctl;
  dpStat_t stat;

  mem_pattern_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctl   (ctl),
    .done  (done)
  );

  mem_pattern_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PASSES (PASSES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .stat      (stat),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .err       (err),
    .failIndex (failIndex)
  );

  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn)); // R3

  AST_ERR_ENDS_TEST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done); // R5

endmodule

// File: tb/mem_pattern_tester_bench.sv
module mem_pattern_tester_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 1024;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic        wrEn, rdEn, done, err;
  logic [9:0]  wrAddr, rdAddr, failIndex;
  logic [31:0] wrData, rdData;

  int checks = 0;
  int errors = 0;

  // Memory model and fault injection
  logic [31:0] mem [WORDS];
  logic        faultOn;
  int          faultAddr, faultPass;
  logic [31:0] faultMask;
  int          wrCount, rdCount, wrBad, orderBad, rdSeqBad;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_pattern_tester u_mem_pattern_tester (
    .clk(clk), .rstN(rstN), .start(start),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .done(done), .err(err), .failIndex(failIndex)
  );

  function automatic logic [31:0] expWord(input int a);
    int grp = a / 4;
    int slot = a % 4;
    logic [31:0] w = 32'h0;
    if (((grp >> (2*slot)) & 1) != 0)     w = w | 32'h0000_FFFF;
    if (((grp >> (2*slot + 1)) & 1) != 0) w = w | 32'hFFFF_0000;
    return w;
  endfunction

  always @(posedge clk) begin
    if (wrEn) begin
      mem[wrAddr] <= wrData;
      if (wrData != expWord(int'(wrAddr))) wrBad <= wrBad + 1;
      if (int'(wrAddr) != wrCount) wrBad <= wrBad + 1;
      if (rdCount != 0) orderBad <= orderBad + 1;
      wrCount <= wrCount + 1;
    end
    if (rdEn) begin
      if (int'(rdAddr) != rdCount % WORDS) rdSeqBad <= rdSeqBad + 1;
      if (faultOn && int'(rdAddr) == faultAddr && rdCount / WORDS == faultPass)
        rdData <= mem[rdAddr] ^ faultMask;
      else
        rdData <= mem[rdAddr];
      rdCount <= rdCount + 1;
    end
    if (wrEn && rdEn) orderBad <= orderBad + 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Runs one test; midStart pulses start while busy
  task automatic runTest(input logic fOn, input int fAddr, input int fPass,
                         input logic [31:0] fMask, input logic midStart);
    int guard;
    int expReads;
    int rdAtDone;
    faultOn = fOn; faultAddr = fAddr; faultPass = fPass; faultMask = fMask;
    @(negedge clk);
    wrCount = 0; rdCount = 0; wrBad = 0; orderBad = 0; rdSeqBad = 0;
    pulseStart();
    check(done == 1'b0 && err == 1'b0, "R9", int'(done), 0);
    if (midStart) begin
      repeat (700) @(negedge clk);
      pulseStart();
      repeat (1500) @(negedge clk);
      pulseStart();
    end
    guard = 0;
    while (!done && guard < 10000) begin @(negedge clk); guard++; end
    check(guard < 10000, "watchdog", guard, 10000);
    expReads = fOn ? (fPass * WORDS + fAddr + 1) : 2 * WORDS;
    check(wrCount == WORDS, "R3", wrCount, WORDS);
    check(wrBad == 0, "R2", wrBad, 0);
    check(orderBad == 0, "R3", orderBad, 0);
    check(rdSeqBad == 0, "R4", rdSeqBad, 0);
    check(rdCount == expReads, fOn ? "R5" : "R4", rdCount, expReads);
    check(err == fOn, fOn ? (fPass == 1 ? "R6" : "R5") : "R7", int'(err), int'(fOn));
    check(int'(failIndex) == (fOn ? fAddr : 0), fOn ? "R5" : "R7",
          int'(failIndex), fOn ? fAddr : 0);
    rdAtDone = rdCount;
    repeat (20) @(negedge clk);
    check(done == 1'b1 && rdCount == rdAtDone && !wrEn && !rdEn, "R7", rdCount, rdAtDone);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; start = 1'b0; faultOn = 1'b0;
    faultAddr = 0; faultPass = 0; faultMask = 0;
    wrCount = 0; rdCount = 0; wrBad = 0; orderBad = 0; rdSeqBad = 0;
    repeat (4) @(negedge clk);
    check(!done && !err && failIndex == 0 && !wrEn && !rdEn, "R1", int'(done), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !err && failIndex == 0 && !wrEn && !rdEn, "R1", int'(err), 0);

    runTest(1'b0, 0, 0, 32'h0, 1'b0);            // clean, R4
    for (int i = 0; i < WORDS; i++)
      check(mem[i] == expWord(i), "R2", int'(mem[i]), int'(expWord(i)));
    runTest(1'b1, 0, 0, 32'h1, 1'b0);            // first word, first sweep
    runTest(1'b1, 1023, 0, 32'h8000_0000, 1'b0); // last word, first sweep
    runTest(1'b1, 0, 1, 32'h0001_0000, 1'b0);    // R6 first word second sweep
    runTest(1'b1, 1023, 1, 32'hFFFF_FFFF, 1'b0); // R6 last word second sweep
    runTest(1'b0, 0, 0, 32'h0, 1'b0);            // R9 clean after failure
    runTest(1'b0, 0, 0, 32'h0, 1'b1);            // R8 start while busy
    runTest(1'b1, 517, 1, 32'h0000_0100, 1'b1);  // R8 with fault
    for (int n = 0; n < 8; n++) begin
      int a = int'($urandom % WORDS);
      int p = int'($urandom % 2);
      logic [31:0] m = $urandom | 32'h1;
      runTest(1'b1, a, p, m, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule